// File: doc/BRIEF.md
# Direct-Mapped Instruction Translation Buffer

This block translates instruction-fetch virtual addresses into physical addresses. It holds 64 entries in a direct-mapped array. Each entry covers an 8 KB page and is chosen by six bits of the virtual address. The fetch side presents an enable and a 32-bit virtual address. On the next clock the block returns:

- a result-valid flag
- a hit flag
- the physical page number and the full physical address
- user and supervisor execute permissions
- a cache-inhibit attribute

Software fills and inspects the entries through a register port, which has two banks of per-entry registers. The match bank holds the tag and the valid flag. The translate bank holds the physical page and its attributes. Every entry is packed into a narrow stored form: a 13-bit tag, a 19-bit page number, a valid flag, two permission bits and one cache-inhibit bit. A register read unpacks these fields into fixed bit positions.

Top module: `ifetch_tlb`

## Requirements
- R1: After reset every valid flag is clear, so no lookup hits until software writes an entry. The read-data output is zero and lk_vld_o is low.
- R2: lk_vld_o is high exactly in the cycle after a cycle with lk_en_i high. The lookup outputs describe the address presented in the most recent enabled cycle.
- R3: Bits 18:13 of the virtual address select the entry and bits 31:19 are compared with its stored tag. lk_hit_o is high only when the result is valid, the entry's valid flag is set and the tags are equal.
- R4: lk_paddr_o equals the entry's 19-bit page number in bits 31:13, joined with bits 12:0 of the looked-up virtual address.
- R5: lk_uxe_o, lk_sxe_o and lk_ci_o return the stored translate-word bits 7, 6 and 1 of the selected entry.
- R6: The match register of entry n is at address 0x1200+n. A write stores data bits 31:19 as the tag and bit 0 as the valid flag. A read returns the tag in 31:19, n in 18:13, the valid flag in bit 0 and zero elsewhere.
- R7: The translate register of entry n is at address 0x1300+n. A write stores data bits 31:13 as the page number, bit 7 as user execute, bit 6 as supervisor execute and bit 1 as cache inhibit. A read returns these fields in the same places and zero elsewhere.
- R8: An access to any address outside 0x1200–0x123F and 0x1300–0x133F changes no entry. A read of such an address returns zero.
- R9: reg_rdat_o updates one cycle after a read access (reg_cs_i high, reg_we_i low). In every other cycle it holds its value.
- R10: If a register write and a lookup target the same entry in one cycle, the lookup output in the next cycle reflects the newly written content.
- R11: An entry whose valid flag is clear never hits, even when its tag matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_en_i | input | 1 | Lookup request |
| lk_vaddr_i | input | 32 | Virtual fetch address |
| lk_vld_o | output | 1 | Lookup result valid |
| lk_hit_o | output | 1 | Translation hit |
| lk_ppn_o | output | 19 | Physical page number |
| lk_paddr_o | output | 32 | Translated physical address |
| lk_uxe_o | output | 1 | User execute permitted |
| lk_sxe_o | output | 1 | Supervisor execute permitted |
| lk_ci_o | output | 1 | Cache inhibit attribute |
| reg_cs_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | Register write when high, read when low |
| reg_addr_i | input | 16 | Register address |
| reg_wdat_i | input | 32 | Register write data |
| reg_rdat_o | output | 32 | Register read data |

## Verification
The bench fills all 64 entries with distinct tags, page numbers and attribute patterns. The write data carries ones in every unimplemented bit and a wrong index in the match word. A design that failed to mask those bits, or that echoed written data instead of the entry index, shows up on read-back.

Every entry is then looked up with a matching tag and with a tag that differs in its lowest bit. One entry is left invalid, which exposes an index/tag split that is off by one and a hit that ignores the valid flag.

Writes to addresses just past each bank, and to a wrong bank code, must leave entry 0 untouched. A decoder that drops the upper index bits would alias them onto entry 0. A write and a lookup of the same entry in the same cycle must expose the new content, which catches a registered read that samples the array before the write lands.

// File: rtl/itlb_pkg.sv
package itlb_pkg;
  typedef enum logic [1:0] {
    BANK_NONE  = 2'd0,
    BANK_MATCH = 2'd1,
    BANK_XLATE = 2'd2
  } bank_e;

  // bit positions within register words
  localparam int unsigned MW_VALID_BIT = 0;
  localparam int unsigned XW_UXE_BIT   = 7;
  localparam int unsigned XW_SXE_BIT   = 6;
  localparam int unsigned XW_CI_BIT    = 1;
endpackage

// File: rtl/itlb_reg_decode.sv
module itlb_reg_decode
  import itlb_pkg::*;
#(
  parameter int unsigned RA_W       = 16,
  parameter int unsigned IDX_W      = 6,
  parameter logic [15:0] MATCH_BASE = 16'h1200,
  parameter logic [15:0] XLATE_BASE = 16'h1300
) (
  input  logic             cs_i,
  input  logic [RA_W-1:0]  addr_i,
  output bank_e            bank_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [RA_W-1:0] MB = RA_W'(MATCH_BASE);
  localparam logic [RA_W-1:0] XB = RA_W'(XLATE_BASE);

  always_comb begin
    bank_o = BANK_NONE;
    if (cs_i) begin
      if (addr_i[RA_W-1:IDX_W] == MB[RA_W-1:IDX_W])      bank_o = BANK_MATCH;
      else if (addr_i[RA_W-1:IDX_W] == XB[RA_W-1:IDX_W]) bank_o = BANK_XLATE;
    end
  end

  assign idx_o = addr_i[IDX_W-1:0];
endmodule

// File: rtl/itlb_store.sv
module itlb_store #(
  parameter int unsigned IDX_W = 6,
  parameter int unsigned TAG_W = 13,
  parameter int unsigned PPN_W = 19
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_match_i,
  input  logic             wr_xlate_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic             wr_valid_i,
  input  logic [PPN_W-1:0] wr_ppn_i,
  input  logic [2:0]       wr_attr_i,   // {uxe, sxe, ci}
  // port a: lookup, port b: register read
  input  logic [IDX_W-1:0] a_idx_i,
  output logic             a_valid_o,
  output logic [TAG_W-1:0] a_tag_o,
  output logic [PPN_W-1:0] a_ppn_o,
  output logic [2:0]       a_attr_o,
  input  logic [IDX_W-1:0] b_idx_i,
  output logic             b_valid_o,
  output logic [TAG_W-1:0] b_tag_o,
  output logic [PPN_W-1:0] b_ppn_o,
  output logic [2:0]       b_attr_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;
  localparam int unsigned XW    = PPN_W + 3;

  logic [DEPTH-1:0] valid_q;
  logic [TAG_W-1:0] tag_mem [DEPTH];
  logic [XW-1:0]    xl_mem  [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_valid
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                        valid_q[g] <= 1'b0;
      else if (wr_match_i && wr_idx_i == IDX_W'(g))       valid_q[g] <= wr_valid_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_match_i) tag_mem[wr_idx_i] <= wr_tag_i;
    if (wr_xlate_i) xl_mem[wr_idx_i]  <= {wr_ppn_i, wr_attr_i};
  end

  assign a_valid_o          = valid_q[a_idx_i];
  assign a_tag_o            = tag_mem[a_idx_i];
  assign {a_ppn_o, a_attr_o} = xl_mem[a_idx_i];
  assign b_valid_o          = valid_q[b_idx_i];
  assign b_tag_o            = tag_mem[b_idx_i];
  assign {b_ppn_o, b_attr_o} = xl_mem[b_idx_i];
endmodule

// File: rtl/itlb_lookup.sv
module itlb_lookup #(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned PAGE_W = 13,
  parameter int unsigned IDX_W  = 6,
  localparam int unsigned TAG_W = VA_W - PAGE_W - IDX_W,
  localparam int unsigned PPN_W = VA_W - PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [VA_W-1:0]   vaddr_i,
  output logic [IDX_W-1:0]  idx_o,
  input  logic              ent_valid_i,
  input  logic [TAG_W-1:0]  ent_tag_i,
  input  logic [PPN_W-1:0]  ent_ppn_i,
  output logic              vld_o,
  output logic              hit_o,
  output logic [VA_W-1:0]   paddr_o
);
  logic              vld_q;
  logic [VA_W-1:0]   va_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      va_q  <= '0;
    end else begin
      vld_q <= en_i;
      if (en_i) va_q <= vaddr_i;
    end
  end

  // array read uses the held index, so a same-cycle write is seen next cycle
  assign idx_o   = va_q[PAGE_W +: IDX_W];
  assign vld_o   = vld_q;
  assign hit_o   = vld_q && ent_valid_i && (ent_tag_i == va_q[VA_W-1 -: TAG_W]);
  assign paddr_o = {ent_ppn_i, va_q[PAGE_W-1:0]};
endmodule

// File: rtl/ifetch_tlb.sv
module ifetch_tlb
  import itlb_pkg::*;
#(
  parameter int unsigned VA_W       = 32,
  parameter int unsigned PAGE_W     = 13,
  parameter int unsigned IDX_W      = 6,
  parameter int unsigned RA_W       = 16,
  parameter logic [15:0] MATCH_BASE = 16'h1200,
  parameter logic [15:0] XLATE_BASE = 16'h1300,
  localparam int unsigned TAG_W     = VA_W - PAGE_W - IDX_W,
  localparam int unsigned PPN_W     = VA_W - PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_en_i,
  input  logic [VA_W-1:0]   lk_vaddr_i,
  output logic              lk_vld_o,
  output logic              lk_hit_o,
  output logic [PPN_W-1:0]  lk_ppn_o,
  output logic [VA_W-1:0]   lk_paddr_o,
  output logic              lk_uxe_o,
  output logic              lk_sxe_o,
  output logic              lk_ci_o,
  input  logic              reg_cs_i,
  input  logic              reg_we_i,
  input  logic [RA_W-1:0]   reg_addr_i,
  input  logic [VA_W-1:0]   reg_wdat_i,
  output logic [VA_W-1:0]   reg_rdat_o
);
  bank_e             bank;
  logic [IDX_W-1:0]  r_idx, l_idx;
  logic              a_valid, b_valid;
  logic [TAG_W-1:0]  a_tag, b_tag;
  logic [PPN_W-1:0]  a_ppn, b_ppn;
  logic [2:0]        a_attr, b_attr, w_attr;
  logic              wr_m, wr_x;
  logic [VA_W-1:0]   rword, rdat_q;

  itlb_reg_decode #(
    .RA_W(RA_W), .IDX_W(IDX_W), .MATCH_BASE(MATCH_BASE), .XLATE_BASE(XLATE_BASE)
  ) dec_i (
    .cs_i(reg_cs_i), .addr_i(reg_addr_i), .bank_o(bank), .idx_o(r_idx)
  );

  assign wr_m   = reg_we_i && bank == BANK_MATCH;
  assign wr_x   = reg_we_i && bank == BANK_XLATE;
  assign w_attr = {reg_wdat_i[XW_UXE_BIT], reg_wdat_i[XW_SXE_BIT], reg_wdat_i[XW_CI_BIT]};

  itlb_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .PPN_W(PPN_W)) store_i (
    .clk_i, .rst_ni,
    .wr_match_i(wr_m), .wr_xlate_i(wr_x), .wr_idx_i(r_idx),
    .wr_tag_i(reg_wdat_i[VA_W-1 -: TAG_W]), .wr_valid_i(reg_wdat_i[MW_VALID_BIT]),
    .wr_ppn_i(reg_wdat_i[VA_W-1 -: PPN_W]), .wr_attr_i(w_attr),
    .a_idx_i(l_idx), .a_valid_o(a_valid), .a_tag_o(a_tag), .a_ppn_o(a_ppn), .a_attr_o(a_attr),
    .b_idx_i(r_idx), .b_valid_o(b_valid), .b_tag_o(b_tag), .b_ppn_o(b_ppn), .b_attr_o(b_attr)
  );

  itlb_lookup #(.VA_W(VA_W), .PAGE_W(PAGE_W), .IDX_W(IDX_W)) look_i (
    .clk_i, .rst_ni, .en_i(lk_en_i), .vaddr_i(lk_vaddr_i), .idx_o(l_idx),
    .ent_valid_i(a_valid), .ent_tag_i(a_tag), .ent_ppn_i(a_ppn),
    .vld_o(lk_vld_o), .hit_o(lk_hit_o), .paddr_o(lk_paddr_o)
  );

  assign lk_ppn_o = a_ppn;
  assign {lk_uxe_o, lk_sxe_o, lk_ci_o} = a_attr;

  // unpack stored entry into register layout
  always_comb begin
    rword = '0;
    unique case (bank)
      BANK_MATCH: begin
        rword[VA_W-1 -: TAG_W]  = b_tag;
        rword[PAGE_W +: IDX_W]  = r_idx;
        rword[MW_VALID_BIT]     = b_valid;
      end
      BANK_XLATE: begin
        rword[VA_W-1 -: PPN_W]  = b_ppn;
        rword[XW_UXE_BIT]       = b_attr[2];
        rword[XW_SXE_BIT]       = b_attr[1];
        rword[XW_CI_BIT]        = b_attr[0];
      end
      default: rword = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   rdat_q <= '0;
    else if (reg_cs_i && !reg_we_i) rdat_q <= rword;
  end
  assign reg_rdat_o = rdat_q;

  // write-data bits with no storage behind them
  logic unused_wdat;
  assign unused_wdat = ^{reg_wdat_i[PAGE_W-1:XW_UXE_BIT+1], reg_wdat_i[XW_SXE_BIT-1:XW_CI_BIT+1]};
endmodule

// File: rtl/ifetch_tlb_chk.sv
module ifetch_tlb_chk #(
  parameter int unsigned VA_W       = 32,
  parameter int unsigned PAGE_W     = 13,
  parameter int unsigned IDX_W      = 6,
  parameter int unsigned RA_W       = 16,
  parameter logic [15:0] MATCH_BASE = 16'h1200,
  parameter logic [15:0] XLATE_BASE = 16'h1300
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            lk_en_i,
  input logic [VA_W-1:0] lk_vaddr_i,
  input logic            lk_vld_o,
  input logic            lk_hit_o,
  input logic [VA_W-1:0] lk_paddr_o,
  input logic            reg_cs_i,
  input logic            reg_we_i,
  input logic [RA_W-1:0] reg_addr_i,
  input logic [VA_W-1:0] reg_rdat_o
);
  localparam int unsigned SPAN = 1 << IDX_W;
  logic in_bank;
  assign in_bank = (32'(reg_addr_i) >= 32'(MATCH_BASE) && 32'(reg_addr_i) < 32'(MATCH_BASE) + SPAN)
                || (32'(reg_addr_i) >= 32'(XLATE_BASE) && 32'(reg_addr_i) < 32'(XLATE_BASE) + SPAN);

  a_r2_vld_after_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_en_i |=> lk_vld_o);
  a_r2_no_vld_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_en_i |=> !lk_vld_o);
  a_r3_hit_needs_vld: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> lk_vld_o);
  a_r4_offset_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lk_vld_o) |-> lk_paddr_o[PAGE_W-1:0] == $past(lk_vaddr_i[PAGE_W-1:0]));
  a_r8_outside_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_cs_i && !reg_we_i && !in_bank) |=> reg_rdat_o == '0);
  a_r9_rdat_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_cs_i && !reg_we_i) |=> $stable(reg_rdat_o));
endmodule

bind ifetch_tlb ifetch_tlb_chk #(
  .VA_W(VA_W), .PAGE_W(PAGE_W), .IDX_W(IDX_W), .RA_W(RA_W),
  .MATCH_BASE(MATCH_BASE), .XLATE_BASE(XLATE_BASE)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .lk_en_i(lk_en_i), .lk_vaddr_i(lk_vaddr_i),
  .lk_vld_o(lk_vld_o), .lk_hit_o(lk_hit_o), .lk_paddr_o(lk_paddr_o),
  .reg_cs_i(reg_cs_i), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .reg_rdat_o(reg_rdat_o)
);

// File: tb/ifetch_tlb_tb_top.sv
module ifetch_tlb_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_en = 1'b0;
  logic [31:0] lk_va = '0;
  logic        vld, hit, uxe, sxe, ci;
  logic [18:0] ppn;
  logic [31:0] pa;
  logic        cs = 1'b0, we = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdat = '0;
  logic [31:0] rdat;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  ifetch_tlb dut_i (
    .clk_i(clk), .rst_ni(rst_n), .lk_en_i(lk_en), .lk_vaddr_i(lk_va),
    .lk_vld_o(vld), .lk_hit_o(hit), .lk_ppn_o(ppn), .lk_paddr_o(pa),
    .lk_uxe_o(uxe), .lk_sxe_o(sxe), .lk_ci_o(ci),
    .reg_cs_i(cs), .reg_we_i(we), .reg_addr_i(addr), .reg_wdat_i(wdat), .reg_rdat_o(rdat)
  );

  function automatic logic [12:0] tag_of(int i);  return 13'((i * 37 + 5) & 32'h1FFF);    endfunction
  function automatic logic [18:0] ppn_of(int i);  return 19'((i * 2731 + 17) & 32'h7FFFF); endfunction
  function automatic logic        val_of(int i);  return i != 5;                            endfunction
  function automatic logic [12:0] off_of(int i);  return 13'((i * 97 + 3) & 32'h1FFF);    endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  task automatic reg_wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk); cs = 1; we = 1; addr = a; wdat = d;
    @(negedge clk); cs = 0; we = 0;
  endtask

  task automatic reg_rd(logic [15:0] a);
    @(negedge clk); cs = 1; we = 0; addr = a;
    @(negedge clk); cs = 0;
  endtask

  task automatic look(logic [31:0] va);
    @(negedge clk); lk_en = 1; lk_va = va;
    @(negedge clk); lk_en = 0;
  endtask

  // match word write data: junk index and ones in unused bits
  function automatic logic [31:0] mw_wr(int i);
    return {tag_of(i), 6'h2A, 12'hFFF, val_of(i)};
  endfunction
  function automatic logic [31:0] xw_wr(int i);
    return {ppn_of(i), 5'h1F, i[0], i[1], 4'hF, i[2], 1'b1};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual hung run, expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 rdat after reset", rdat, 32'h0);
    chk("R1 vld after reset", {31'b0, vld}, 32'h0);
    rst_n = 1'b1;
    for (int i = 0; i < 64; i++) begin
      look({tag_of(i), 6'(i), 13'h0});
      chk("R1 no hit before writes", {31'b0, hit}, 32'h0);
    end
    reg_rd(16'h1207);
    chk("R1 match word valid clear", rdat & 32'h1, 32'h0);

    for (int i = 0; i < 64; i++) begin
      reg_wr(16'h1200 + 16'(i), mw_wr(i));
      reg_wr(16'h1300 + 16'(i), xw_wr(i));
    end

    // R6/R7 read-back layout
    for (int i = 0; i < 64; i++) begin
      reg_rd(16'h1200 + 16'(i));
      chk("R6 match read", rdat, {tag_of(i), 6'(i), 12'h0, val_of(i)});
      reg_rd(16'h1300 + 16'(i));
      chk("R7 translate read", rdat, {ppn_of(i), 5'h0, i[0], i[1], 4'h0, i[2], 1'b0});
    end

    // R2..R5, R11: lookups
    for (int i = 0; i < 64; i++) begin
      look({tag_of(i), 6'(i), off_of(i)});
      chk("R2 vld one cycle later", {31'b0, vld}, 32'h1);
      chk(i == 5 ? "R11 invalid entry misses" : "R3 hit on match", {31'b0, hit}, {31'b0, val_of(i)});
      chk("R4 paddr", pa, {ppn_of(i), off_of(i)});
      chk("R5 attributes", {29'b0, uxe, sxe, ci}, {29'b0, i[0], i[1], i[2]});
      look({tag_of(i) ^ 13'h1, 6'(i), off_of(i)});
      chk("R3 miss on tag mismatch", {31'b0, hit}, 32'h0);
    end
    @(negedge clk);
    chk("R2 vld low when idle", {31'b0, vld}, 32'h0);

    // R8: out-of-range writes leave entry 0 alone, reads give zero
    reg_wr(16'h1240, 32'hFFFF_FFFF);
    reg_wr(16'h1340, 32'hFFFF_FFFF);
    reg_wr(16'h1100, 32'hFFFF_FFFF);
    reg_wr(16'h12C0, 32'hFFFF_FFFF);
    reg_wr(16'h1380, 32'hFFFF_FFFF);
    reg_rd(16'h1200);
    chk("R8 match entry 0 untouched", rdat, {tag_of(0), 6'd0, 12'h0, val_of(0)});
    reg_rd(16'h1300);
    chk("R8 translate entry 0 untouched", rdat, {ppn_of(0), 13'h0});
    reg_rd(16'h1240);
    chk("R8 read outside bank", rdat, 32'h0);
    reg_rd(16'h1400);
    chk("R8 read other bank code", rdat, 32'h0);

    // R9: read data holds across idle and write cycles
    reg_rd(16'h1301);
    chk("R9 read data", rdat, {ppn_of(1), 5'h0, 1'b1, 1'b0, 4'h0, 1'b0, 1'b0});
    repeat (3) @(negedge clk);
    reg_wr(16'h1230, mw_wr(48));
    chk("R9 read data held", rdat, {ppn_of(1), 5'h0, 1'b1, 1'b0, 4'h0, 1'b0, 1'b0});

    // R10: write and lookup of the same entry in one cycle
    @(negedge clk);
    cs = 1; we = 1; addr = 16'h1303; wdat = {19'h12345, 13'h0C2};
    lk_en = 1; lk_va = {tag_of(3), 6'd3, 13'h0AB};
    @(negedge clk); cs = 0; we = 0; lk_en = 0;
    chk("R10 new ppn seen", {13'b0, ppn}, {13'b0, 19'h12345});
    chk("R10 new attributes seen", {29'b0, uxe, sxe, ci}, 32'h7);
    chk("R10 hit kept", {31'b0, hit}, 32'h1);
    @(negedge clk);
    cs = 1; we = 1; addr = 16'h1204; wdat = {tag_of(4), 19'h0};
    lk_en = 1; lk_va = {tag_of(4), 6'd4, 13'h0};
    @(negedge clk); cs = 0; we = 0; lk_en = 0;
    chk("R10 invalidate seen", {31'b0, hit}, 32'h0);
    look({tag_of(4), 6'd4, 13'h0});
    chk("R11 invalidated entry misses", {31'b0, hit}, 32'h0);

    summary();
  end
endmodule